// File: doc/BRIEF.md
# Pulse-Swallow Integer-N Divider Pair

This block holds the two digital counters of an integer-N frequency loop. The feedback path divides its clock by N = 16·B + A. It does this with a dual-modulus prescaler, modelled as a digital divide-by-16/17 stage. A 9-bit main counter and a 4-bit swallow counter steer that prescaler. The reference path divides the same clock by R. Each path emits a one-cycle pulse per division period, which is the form a phase-frequency detector consumes.

The divider settings come from one of two places. With the preset-select input high, a 2-bit code picks one of three built-in (B, A) pairs, and the reference ratio is a built-in value that gives the comparison rate those pairs were chosen for. With the preset-select input low, the programmed B, A and R inputs apply. A new setting is picked up by each path only when its current division period completes, so no period is ever cut short. A synchronous enable holds both paths at the start of a period with their outputs low.

Top module: `pswallow_div`

## Requirements
- R1: With `en` high, `fb_pulse` is high for one cycle every N = 16·B + A clock cycles. The first pulse appears N rising edges after `en` is first sampled high.
- R2: Within a feedback period, the prescaler runs divide-by-17 for the first A prescaler periods and divide-by-16 for the remaining B − A. An A of 0 therefore gives exactly 16·B.
- R3: With `en` high, `ref_pulse` is high for one cycle every R clock cycles. The first pulse appears R rising edges after enable.
- R4: With `use_preset` = 1, `preset_sel` 00 gives (B, A) = (88, 15), 01 gives (191, 4) and 10 gives (229, 9). Code 11 behaves as 10. The reference ratio is then 160 (parameter `PRESET_R`).
- R5: With `use_preset` = 0, the programmed `prog_b`, `prog_a` and `prog_r` set the ratios. With `use_preset` = 1, changes on those inputs have no effect on either pulse period.
- R6: A change of setting while running takes effect only after the current feedback or reference period has ended. The period in progress keeps its old length.
- R7: While `en` is low, both outputs are low and both counters stay at the start of a period. Raising `en` again restarts both latencies from the full N and R.
- R8: Synchronous active-high `rst` forces both outputs low on the next edge.
- R9: Every pulse on `fb_pulse` and `ref_pulse` lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided clock, also used for all state |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low holds both counters and quiets the outputs |
| use_preset | input | 1 | 1 selects the built-in divider set, 0 the programmed values |
| preset_sel | input | 2 | Built-in set code (11 falls back to 10) |
| prog_b | input | 9 | Programmed main counter value B (1..511) |
| prog_a | input | 4 | Programmed swallow count A (0..15, below B) |
| prog_r | input | 9 | Programmed reference ratio R (2..511) |
| fb_pulse | output | 1 | One-cycle pulse per feedback division period |
| ref_pulse | output | 1 | One-cycle pulse per reference division period |

## Verification
The assertions rely on the selected setting always being legal: A strictly below B, B at least 1, and R at least 2. The swallow-ordering and single-cycle checks only hold under those conditions. The stimulus changes B, A and R together in one assignment at a falling edge, so no intermediate illegal pair is ever sampled. Every programmed and built-in set it applies satisfies those bounds, including the extremes B = 1, A = 0, B = 511, A = 15 and R = 2 or 511.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

  typedef enum logic [1:0] {
    PSET_LOW  = 2'b00,
    PSET_MID  = 2'b01,
    PSET_HIGH = 2'b10,
    PSET_RSVD = 2'b11
  } pset_e;

endpackage

// File: rtl/pswd_cfg_sel.sv
module pswd_cfg_sel
  import pswd_pkg::*;
#(
  parameter int B_W      = 9,
  parameter int A_W      = 4,
  parameter int R_W      = 9,
  parameter int P0_B     = 88,
  parameter int P0_A     = 15,
  parameter int P1_B     = 191,
  parameter int P1_A     = 4,
  parameter int P2_B     = 229,
  parameter int P2_A     = 9,
  parameter int PRESET_R = 160
) (
  input  logic           use_preset,
  input  logic [1:0]     preset_sel,
  input  logic [B_W-1:0] prog_b,
  input  logic [A_W-1:0] prog_a,
  input  logic [R_W-1:0] prog_r,
  output logic [B_W-1:0] sel_b,
  output logic [A_W-1:0] sel_a,
  output logic [R_W-1:0] sel_r
);

  logic [B_W-1:0] pre_b;
  logic [A_W-1:0] pre_a;

  always_comb begin
    unique case (pset_e'(preset_sel))
      PSET_LOW: begin pre_b = B_W'(P0_B); pre_a = A_W'(P0_A); end
      PSET_MID: begin pre_b = B_W'(P1_B); pre_a = A_W'(P1_A); end
      default:  begin pre_b = B_W'(P2_B); pre_a = A_W'(P2_A); end
    endcase
  end

  assign sel_b = use_preset ? pre_b : prog_b;
  assign sel_a = use_preset ? pre_a : prog_a;
  assign sel_r = use_preset ? R_W'(PRESET_R) : prog_r;

endmodule

// File: rtl/pswd_fb_div.sv
module pswd_fb_div #(
  parameter int B_W = 9,
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [B_W-1:0] new_b,
  input  logic [A_W-1:0] new_a,
  output logic           cyc_end,
  output logic [A_W:0]   pre_cnt,
  output logic [B_W-1:0] b_rem,
  output logic [A_W-1:0] a_rem
);

  localparam logic [A_W:0] PRE_BASE = {1'b1, {A_W{1'b0}}};
  localparam logic [A_W:0] PRE_LAST = PRE_BASE - 1'b1;

  logic swallow;
  logic pre_last;

  assign swallow  = (a_rem != '0);
  assign pre_last = swallow ? (pre_cnt == PRE_BASE) : (pre_cnt == PRE_LAST);
  assign cyc_end  = pre_last && (b_rem == B_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre_cnt <= '0;
      b_rem   <= new_b;
      a_rem   <= new_a;
    end else if (pre_last) begin
      pre_cnt <= '0;
      if (b_rem == B_W'(1)) begin
        b_rem <= new_b;
        a_rem <= new_a;
      end else begin
        b_rem <= b_rem - B_W'(1);
        if (swallow) a_rem <= a_rem - A_W'(1);
      end
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pswd_ref_div.sv
module pswd_ref_div #(
  parameter int R_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [R_W-1:0] new_r,
  output logic           cyc_end,
  output logic [R_W-1:0] r_rem
);

  assign cyc_end = (r_rem == R_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !en)   r_rem <= new_r;
    else if (cyc_end) r_rem <= new_r;
    else              r_rem <= r_rem - R_W'(1);
  end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int B_W      = 9,
  parameter int A_W      = 4,
  parameter int R_W      = 9,
  parameter int P0_B     = 88,
  parameter int P0_A     = 15,
  parameter int P1_B     = 191,
  parameter int P1_A     = 4,
  parameter int P2_B     = 229,
  parameter int P2_A     = 9,
  parameter int PRESET_R = 160
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           use_preset,
  input  logic [1:0]     preset_sel,
  input  logic [B_W-1:0] prog_b,
  input  logic [A_W-1:0] prog_a,
  input  logic [R_W-1:0] prog_r,
  output logic           fb_pulse,
  output logic           ref_pulse
);

  logic [B_W-1:0] sel_b;
  logic [A_W-1:0] sel_a;
  logic [R_W-1:0] sel_r;
  logic           fb_end;
  logic           ref_end;
  logic [A_W:0]   fb_pre_cnt;
  logic [B_W-1:0] fb_b_rem;
  logic [A_W-1:0] fb_a_rem;
  logic [R_W-1:0] ref_rem;

  pswd_cfg_sel #(
    .B_W(B_W), .A_W(A_W), .R_W(R_W),
    .P0_B(P0_B), .P0_A(P0_A), .P1_B(P1_B), .P1_A(P1_A),
    .P2_B(P2_B), .P2_A(P2_A), .PRESET_R(PRESET_R)
  ) u_cfg (
    .use_preset(use_preset), .preset_sel(preset_sel),
    .prog_b(prog_b), .prog_a(prog_a), .prog_r(prog_r),
    .sel_b(sel_b), .sel_a(sel_a), .sel_r(sel_r)
  );

  pswd_fb_div #(.B_W(B_W), .A_W(A_W)) u_fb (
    .clk(clk), .rst(rst), .en(en),
    .new_b(sel_b), .new_a(sel_a),
    .cyc_end(fb_end), .pre_cnt(fb_pre_cnt),
    .b_rem(fb_b_rem), .a_rem(fb_a_rem)
  );

  pswd_ref_div #(.R_W(R_W)) u_ref (
    .clk(clk), .rst(rst), .en(en),
    .new_r(sel_r), .cyc_end(ref_end), .r_rem(ref_rem)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      fb_pulse  <= 1'b0;
      ref_pulse <= 1'b0;
    end else begin
      fb_pulse  <= fb_end;
      ref_pulse <= ref_end;
    end
  end

endmodule

// File: rtl/pswd_chk.sv
module pswd_chk #(
  parameter int B_W = 9,
  parameter int A_W = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic           fb_pulse,
  input logic           ref_pulse,
  input logic [A_W:0]   fb_pre_cnt,
  input logic [B_W-1:0] fb_b_rem,
  input logic [A_W-1:0] fb_a_rem
);

  localparam logic [A_W:0] PRE_BASE = {1'b1, {A_W{1'b0}}};

  AST_FB_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> !fb_pulse); // R9

  AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ref_pulse |=> !ref_pulse); // R9

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!fb_pulse && !ref_pulse)); // R7

  AST_RST_CLEARS: assert property (@(posedge clk)
    rst |=> (!fb_pulse && !ref_pulse)); // R8

  AST_SEVENTEEN_ONLY_SWALLOW: assert property (@(posedge clk) disable iff (rst)
    (fb_pre_cnt == PRE_BASE) |-> (fb_a_rem != '0)); // R2

  AST_SWALLOW_INSIDE_MAIN: assert property (@(posedge clk) disable iff (rst)
    en |-> (fb_b_rem > B_W'(fb_a_rem))); // R2

endmodule

bind pswallow_div pswd_chk #(.B_W(B_W), .A_W(A_W)) u_chk (
  .clk(clk), .rst(rst), .en(en),
  .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
  .fb_pre_cnt(fb_pre_cnt), .fb_b_rem(fb_b_rem), .fb_a_rem(fb_a_rem)
);

// File: tb/pswallow_div_bench.sv
`timescale 1ns/1ps
module pswallow_div_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       use_preset = 1'b1;
  logic [1:0] preset_sel = 2'b00;
  logic [8:0] prog_b = 9'd5;
  logic [3:0] prog_a = 4'd3;
  logic [8:0] prog_r = 9'd7;
  logic       fb_pulse;
  logic       ref_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pswallow_div u_pswallow_div (
    .clk(clk), .rst(rst), .en(en),
    .use_preset(use_preset), .preset_sel(preset_sel),
    .prog_b(prog_b), .prog_a(prog_a), .prog_r(prog_r),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
  endtask

  task automatic set_prog(input int b, input int a, input int r);
    @(negedge clk);
    use_preset = 1'b0; prog_b = 9'(b); prog_a = 4'(a); prog_r = 9'(r);
  endtask

  task automatic set_preset(input logic [1:0] code);
    @(negedge clk);
    use_preset = 1'b1; preset_sel = code;
  endtask

  // After restart(): first pulse N (or R) edges after enable, then fixed period.
  task automatic meas(input bit pick_ref, input int exp, input string req);
    int t0 = -1;
    int t1 = -1;
    int t2 = -1;
    int highs = 0;
    for (int k = 1; k <= 3 * exp; k++) begin
      @(negedge clk);
      if (pick_ref ? ref_pulse : fb_pulse) begin
        highs++;
        if (t0 < 0) t0 = k;
        else if (t1 < 0) t1 = k;
        else if (t2 < 0) t2 = k;
      end
    end
    chk(req, pick_ref ? "ref first" : "fb first", t0, exp);
    chk(req, pick_ref ? "ref period" : "fb period", t1 - t0, exp);
    chk(req, pick_ref ? "ref period2" : "fb period2", t2 - t1, exp);
    chk("R9", pick_ref ? "ref high cycles" : "fb high cycles", highs, 3);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8", "fb in reset", int'(fb_pulse), 0);
    chk("R8", "ref in reset", int'(ref_pulse), 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_presets();
    set_preset(2'b00); restart(); meas(1'b0, 1423, "R4");
    restart(); meas(1'b1, 160, "R4");
    set_preset(2'b01); restart(); meas(1'b0, 3060, "R4");
    set_preset(2'b10); restart(); meas(1'b0, 3673, "R4");
    set_preset(2'b11); restart(); meas(1'b0, 3673, "R4");
  endtask

  task automatic t_programmed();
    set_prog(5, 3, 7);     restart(); meas(1'b0, 83, "R1"); restart(); meas(1'b1, 7, "R3");
    set_prog(1, 0, 2);     restart(); meas(1'b0, 16, "R2"); restart(); meas(1'b1, 2, "R3");
    set_prog(10, 0, 511);  restart(); meas(1'b0, 160, "R2"); restart(); meas(1'b1, 511, "R3");
    set_prog(10, 9, 100);  restart(); meas(1'b0, 169, "R2");
    set_prog(511, 15, 3);  restart(); meas(1'b0, 8191, "R5");
  endtask

  task automatic t_prog_ignored();
    int fbt = 0;
    int ft[3] = '{0, 0, 0};
    int rc = 0;
    set_prog(7, 2, 5);
    set_preset(2'b00);
    restart();
    for (int k = 1; k <= 3 * 1423; k++) begin
      @(negedge clk);
      if (fb_pulse && fbt < 3) begin ft[fbt] = k; fbt++; end
      if (ref_pulse) rc++;
      if (k == 100) begin prog_b = 9'd3; prog_a = 4'd1; prog_r = 9'd4; end
    end
    chk("R5", "fb first with prog changed", ft[0], 1423);
    chk("R5", "fb period with prog changed", ft[2] - ft[1], 1423);
    chk("R5", "ref pulse count with prog changed", rc, (3 * 1423) / 160);
  endtask

  task automatic t_mid_change();
    int fbt = 0;
    int ft[3] = '{0, 0, 0};
    int rt = 0;
    int rts[6] = '{0, 0, 0, 0, 0, 0};
    set_prog(20, 0, 100);
    restart();
    for (int k = 1; k <= 720; k++) begin
      @(negedge clk);
      if (fb_pulse && fbt < 3) begin ft[fbt] = k; fbt++; end
      if (ref_pulse && rt < 6) begin rts[rt] = k; rt++; end
      if (k == 370) begin prog_b = 9'd4; prog_a = 4'd1; prog_r = 9'd9; end
    end
    chk("R6", "fb pulse before change", ft[0], 320);
    chk("R6", "fb old period completes", ft[1], 640);
    chk("R6", "fb new period", ft[2] - ft[1], 65);
    chk("R6", "ref old period completes", rts[3], 400);
    chk("R6", "ref new period", rts[4] - rts[3], 9);
  endtask

  task automatic t_enable_hold();
    int hi = 0;
    set_prog(6, 2, 11);
    restart();
    repeat (40) @(negedge clk);
    en = 1'b0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (fb_pulse || ref_pulse) hi++;
    end
    chk("R7", "pulses while disabled", hi, 0);
    en = 1'b1;
    meas(1'b0, 98, "R7");
    restart();
    meas(1'b1, 11, "R7");
  endtask

  task automatic t_reset_midrun();
    int hi = 0;
    set_prog(1, 0, 2);
    restart();
    repeat (10) @(negedge clk);
    rst = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (fb_pulse || ref_pulse) hi++;
    end
    chk("R8", "pulses during reset", hi, 0);
    rst = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    en = 1'b1;
    t_reset();
    t_presets();
    t_programmed();
    t_prog_ignored();
    t_mid_change();
    t_enable_hold();
    t_reset_midrun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule